// File: doc/BRIEF.md
# Host Bus Register Access Controller

This block is the host-facing front end of a wide search-memory device on a 16-bit bus. The host has no address bus. Each bus cycle arrives as a single-clock strobe, and three active-low control levels are sampled with it: chip enable, command/data select and write. The block sorts the cycle into one of four kinds: command write, command read, data write or data read. It then decides which internal register or array port the cycle reaches.

The target of a cycle depends on state left by earlier cycles, not on an address:

- A command write loads the instruction register unless something earlier has redirected it. The redirection can be a one-shot instruction or the address-follow flag of the previous instruction.
- A command read returns the next-free address unless it has been redirected, or unless it continues a two-part status read.
- Data cycles go to a persistent source (reads) or a persistent destination (writes). These stay in force until a select instruction changes them.

A page/device-select comparison decides whether the device answers at all. The match array is outside the block. It is reached through array strobes, a location select and a combinational read-data input.

Top module: `hbac_top`

## Requirements
- R1: A strobe with ce_n high changes no state, raises no strobe, and leaves rdata_oe low in the following cycle.
- R2: When no redirection, address flag or status continuation is pending, a command write (cd_n=0, wr_n=0) loads instr_q and pulses instr_stb in the strobe cycle. A command read (cd_n=0, wr_n=1) in the same situation returns nfa_in.
- R3: A loaded instruction that is not a control instruction and has bit 11 set makes the next accepted cycle, if it is a command write, load the address register. Any accepted cycle clears the flag.
- R4: A control instruction has bits 15:12 = 4'hF and bits 7:3 = 0. Its bits 10:8 = 1 mark a one-shot redirection, with target code in bits 2:0: 0 address, 1 control, 2 page, 3 segment control, 4 device select, 5 status, 6 source readback, 7 destination readback. Only the next accepted cycle uses the redirection, and only if that cycle is a command cycle. A redirected write to codes 5 to 7 changes nothing.
- R5: A command read redirected to status returns status_in[15:0]. If the next accepted cycle is also a command read, it returns status_in[31:16]. A third read, or any other cycle in between, falls back to the default.
- R6: Bits 10:8 = 2 select the persistent source, with codes 0 comparand, 1 mask 1, 2 mask 2, 3 array at address, 5 array at match. Bits 10:8 = 3 select the persistent destination, with those codes plus 4 array at next free. A code outside the valid set leaves the current choice unchanged. Data writes go to the destination and data reads come from the source.
- R7: A data write to an array target pulses arr_wr_stb in the strobe cycle. A data read from an array target pulses arr_rd_stb and returns array_rdata. In both cases arr_sel = 0 for the address register, 1 for next free and 2 for match.
- R8: Reads are accepted only when device select equals page. Writes are accepted when device select equals page or is 16'hFFFF. A write to device select is always accepted, whether it is a redirected write or the loading of a redirection instruction with code 4. Cycles that are not accepted change no state.
- R9: A command read redirected with code 6 returns {DEV_ID, bits 11:0 of the last accepted source select}. With code 7 it returns {4'h0, bits 11:0 of the last accepted destination select}.
- R10: rdata_oe is high in exactly the cycle after an accepted read strobe, with rdata valid in that cycle.
- R11: After reset, the comparand is the source and destination, and all registers are zero. The readback words are 12'h200 for the source and 12'h300 for the destination, and rdata_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_stb | input | 1 | One-clock bus cycle strobe |
| ce_n | input | 1 | Chip enable, active low |
| cd_n | input | 1 | Low for command cycle, high for data cycle |
| wr_n | input | 1 | Low for write, high for read |
| wdata | input | 16 | Host write data |
| nfa_in | input | 16 | Next-free address from the array |
| status_in | input | 32 | Device status word |
| array_rdata | input | 16 | Array read data, valid in the strobe cycle |
| rdata | output | 16 | Registered read data |
| rdata_oe | output | 1 | Read data drive enable |
| instr_stb | output | 1 | Instruction load pulse |
| instr_q | output | 16 | Last loaded instruction |
| addr_q | output | 16 | Address register |
| arr_wr_stb | output | 1 | Array write pulse |
| arr_rd_stb | output | 1 | Array read pulse |
| arr_sel | output | 2 | Array location select |

## Verification
The deselection gate and the one-shot redirection meet in one cycle when the page and device-select registers differ and the host tries to reach device select. The gate then has to accept a write that the redirection logic has only just classified, and reject every other cycle without consuming the pending state. The bench provokes this by writing page and device-select values that mismatch, that match, or that equal 16'hFFFF. It then issues both redirection-instruction writes and redirected writes. A bench model judges which cycles are accepted and compares later reads against it. The status continuation is judged the same way: a random mix of cycles falls between the low and high halves.

// File: rtl/hbac_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the host bus access controller.
// Assumes a 16-bit host word; instruction field positions are fixed.
package hbac_pkg;
    localparam int HW       = 16;
    localparam int SW       = 2 * HW;
    localparam int IW       = 12;          // stored select-instruction bits
    localparam int FLAG_BIT = 11;
    localparam logic [3:0] OPC_CTRL  = 4'hF;
    localparam logic [2:0] SUB_REDIR = 3'd1;
    localparam logic [2:0] SUB_PSRC  = 3'd2;
    localparam logic [2:0] SUB_PDST  = 3'd3;

    typedef enum logic [2:0] {CY_IDLE, CY_CMD_WR, CY_CMD_RD, CY_DAT_WR, CY_DAT_RD} cyc_e;
    typedef enum logic [2:0] {RT_ADDR, RT_CTRL, RT_PAGE, RT_SEGC, RT_DSEL, RT_STAT, RT_PSRC, RT_PDST} redir_e;
    typedef enum logic [2:0] {PT_CMP, PT_MSK1, PT_MSK2, PT_ARR_ADR, PT_ARR_NFA, PT_ARR_HIT, PT_RSV6, PT_RSV7} pers_e;
    typedef enum logic [1:0] {AS_ADDR, AS_NFA, AS_HIT, AS_NONE} asel_e;
    typedef enum logic [3:0] {RS_NFA, RS_ADDR, RS_CTRL, RS_PAGE, RS_SEGC, RS_DSEL, RS_STLO,
                              RS_STHI, RS_PSRC, RS_PDST, RS_CMP, RS_MSK1, RS_MSK2, RS_ARR} rsrc_e;

    typedef struct packed {
        logic addr;
        logic ctrl;
        logic page;
        logic segc;
        logic dsel;
        logic cmp;
        logic msk1;
        logic msk2;
    } host_we_t;
endpackage

// File: rtl/hbac_cycle_class.sv
`timescale 1ns/1ps
// Classifies a strobed bus cycle from the three active-low control levels.
// Assumes the levels are stable during the strobe cycle.
module hbac_cycle_class
    import hbac_pkg::*;
(
    input  logic cyc_stb,
    input  logic ce_n,
    input  logic cd_n,
    input  logic wr_n,
    output cyc_e cyc
);
    // Map control levels onto a cycle kind; disabled chip gives idle.
    always_comb begin
        if (!cyc_stb || ce_n) cyc = CY_IDLE;
        else if (!cd_n)       cyc = wr_n ? CY_CMD_RD : CY_CMD_WR;
        else                  cyc = wr_n ? CY_DAT_RD : CY_DAT_WR;
    end
endmodule

// File: rtl/hbac_access_gate.sv
`timescale 1ns/1ps
// Decides whether the device answers a cycle: selected when device select
// equals page, write-only when device select is all ones, and device-select
// writes always pass.
module hbac_access_gate
    import hbac_pkg::*;
(
    input  cyc_e          cyc,
    input  logic [HW-1:0] page_q,
    input  logic [HW-1:0] dsel_q,
    input  logic          dsel_try,
    output logic          acc
);
    logic sel_match;
    logic wr_only;

    // Acceptance per cycle kind.
    always_comb begin
        sel_match = (dsel_q == page_q);
        wr_only   = (dsel_q == {HW{1'b1}});
        case (cyc)
            CY_CMD_WR, CY_DAT_WR: acc = sel_match || wr_only || dsel_try;
            CY_CMD_RD, CY_DAT_RD: acc = sel_match;
            default:              acc = 1'b0;
        endcase
    end
endmodule

// File: rtl/hbac_route_ctl.sv
`timescale 1ns/1ps
// Holds the routing state (one-shot redirection, address flag, status
// continuation, persistent source/destination) and turns each accepted
// cycle into register enables, a read-source choice or array strobes.
// Assumes acc already includes the deselection decision.
module hbac_route_ctl
    import hbac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  cyc_e          cyc,
    input  logic          acc,
    input  logic [HW-1:0] wdata,
    output logic          dsel_try,
    output host_we_t      we,
    output logic          ld_instr,
    output logic          rd_en,
    output rsrc_e         rd_src,
    output logic          arr_wr,
    output logic          arr_rd,
    output asel_e         arr_sel,
    output logic [IW-1:0] psrc_ins,
    output logic [IW-1:0] pdst_ins
);
    logic        redir_vld;
    redir_e      redir_tgt;
    logic        aflag;
    logic        st_hi;
    pers_e       psrc;
    pers_e       pdst;
    logic        ins_ctl;
    logic [2:0]  ins_sub;
    logic [2:0]  ins_code;
    logic        via_ins;

    function automatic logic src_ok(input logic [2:0] c);
        return (c <= 3'd3) || (c == 3'(PT_ARR_HIT));
    endfunction

    function automatic logic dst_ok(input logic [2:0] c);
        return c <= 3'(PT_ARR_HIT);
    endfunction

    // Decode the cycle against the routing state.
    always_comb begin
        ins_ctl  = (wdata[15:12] == OPC_CTRL) && (wdata[7:3] == 5'd0);
        ins_sub  = wdata[10:8];
        ins_code = wdata[2:0];
        via_ins  = (cyc == CY_CMD_WR) && !redir_vld && !aflag;
        dsel_try = (cyc == CY_CMD_WR) &&
                   ((redir_vld && redir_tgt == RT_DSEL) ||
                    (via_ins && ins_ctl && ins_sub == SUB_REDIR && ins_code == 3'(RT_DSEL)));
        we       = '0;
        ld_instr = 1'b0;
        rd_en    = 1'b0;
        rd_src   = RS_NFA;
        arr_wr   = 1'b0;
        arr_rd   = 1'b0;
        arr_sel  = AS_NONE;
        if (acc) begin
            case (cyc)
                CY_CMD_WR: begin
                    if (redir_vld) begin
                        case (redir_tgt)
                            RT_ADDR: we.addr = 1'b1;
                            RT_CTRL: we.ctrl = 1'b1;
                            RT_PAGE: we.page = 1'b1;
                            RT_SEGC: we.segc = 1'b1;
                            RT_DSEL: we.dsel = 1'b1;
                            default: ;
                        endcase
                    end else if (aflag) begin
                        we.addr = 1'b1;
                    end else begin
                        ld_instr = 1'b1;
                    end
                end
                CY_CMD_RD: begin
                    rd_en = 1'b1;
                    if (redir_vld) begin
                        case (redir_tgt)
                            RT_ADDR: rd_src = RS_ADDR;
                            RT_CTRL: rd_src = RS_CTRL;
                            RT_PAGE: rd_src = RS_PAGE;
                            RT_SEGC: rd_src = RS_SEGC;
                            RT_DSEL: rd_src = RS_DSEL;
                            RT_STAT: rd_src = RS_STLO;
                            RT_PSRC: rd_src = RS_PSRC;
                            default: rd_src = RS_PDST;
                        endcase
                    end else if (st_hi) begin
                        rd_src = RS_STHI;
                    end
                end
                CY_DAT_WR: begin
                    case (pdst)
                        PT_CMP:     we.cmp  = 1'b1;
                        PT_MSK1:    we.msk1 = 1'b1;
                        PT_MSK2:    we.msk2 = 1'b1;
                        PT_ARR_ADR: begin arr_wr = 1'b1; arr_sel = AS_ADDR; end
                        PT_ARR_NFA: begin arr_wr = 1'b1; arr_sel = AS_NFA;  end
                        default:    begin arr_wr = 1'b1; arr_sel = AS_HIT;  end
                    endcase
                end
                CY_DAT_RD: begin
                    rd_en = 1'b1;
                    case (psrc)
                        PT_CMP:     rd_src = RS_CMP;
                        PT_MSK1:    rd_src = RS_MSK1;
                        PT_MSK2:    rd_src = RS_MSK2;
                        PT_ARR_ADR: begin rd_src = RS_ARR; arr_rd = 1'b1; arr_sel = AS_ADDR; end
                        default:    begin rd_src = RS_ARR; arr_rd = 1'b1; arr_sel = AS_HIT;  end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Advance routing state on every accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_vld <= 1'b0;
            redir_tgt <= RT_ADDR;
            aflag     <= 1'b0;
            st_hi     <= 1'b0;
            psrc      <= PT_CMP;
            pdst      <= PT_CMP;
            psrc_ins  <= {1'b0, SUB_PSRC, 5'd0, 3'(PT_CMP)};
            pdst_ins  <= {1'b0, SUB_PDST, 5'd0, 3'(PT_CMP)};
        end else if (acc) begin
            redir_vld <= ld_instr && ins_ctl && (ins_sub == SUB_REDIR);
            redir_tgt <= redir_e'(ins_code);
            aflag     <= ld_instr && !ins_ctl && wdata[FLAG_BIT];
            st_hi     <= (cyc == CY_CMD_RD) && redir_vld && (redir_tgt == RT_STAT);
            if (ld_instr && ins_ctl && ins_sub == SUB_PSRC && src_ok(ins_code)) begin
                psrc     <= pers_e'(ins_code);
                psrc_ins <= wdata[IW-1:0];
            end
            if (ld_instr && ins_ctl && ins_sub == SUB_PDST && dst_ok(ins_code)) begin
                pdst     <= pers_e'(ins_code);
                pdst_ins <= wdata[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/hbac_regfile.sv
`timescale 1ns/1ps
// Host-visible registers, the read multiplexer and the registered read port.
// Assumes write enables and read source are already qualified by acceptance.
module hbac_regfile
    import hbac_pkg::*;
#(
    parameter logic [3:0]    DEV_ID   = 4'h5,
    parameter logic [HW-1:0] PAGE_RST = '0,
    parameter logic [HW-1:0] DSEL_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  host_we_t      we,
    input  logic          ld_instr,
    input  logic [HW-1:0] wdata,
    input  logic          rd_en,
    input  rsrc_e         rd_src,
    input  logic [HW-1:0] nfa_in,
    input  logic [SW-1:0] status_in,
    input  logic [HW-1:0] array_rdata,
    input  logic [IW-1:0] psrc_ins,
    input  logic [IW-1:0] pdst_ins,
    output logic [HW-1:0] rdata,
    output logic          rdata_oe,
    output logic [HW-1:0] instr_q,
    output logic [HW-1:0] addr_q,
    output logic [HW-1:0] page_q,
    output logic [HW-1:0] dsel_q
);
    localparam int PADW = HW - IW;

    logic [HW-1:0] ctrl_q, segc_q, cmp_q, msk1_q, msk2_q, rd_val;

    // Register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q <= '0; addr_q <= '0; ctrl_q <= '0; segc_q <= '0;
            page_q  <= PAGE_RST; dsel_q <= DSEL_RST;
            cmp_q   <= '0; msk1_q <= '0; msk2_q <= '0;
        end else begin
            if (ld_instr) instr_q <= wdata;
            if (we.addr)  addr_q  <= wdata;
            if (we.ctrl)  ctrl_q  <= wdata;
            if (we.page)  page_q  <= wdata;
            if (we.segc)  segc_q  <= wdata;
            if (we.dsel)  dsel_q  <= wdata;
            if (we.cmp)   cmp_q   <= wdata;
            if (we.msk1)  msk1_q  <= wdata;
            if (we.msk2)  msk2_q  <= wdata;
        end
    end

    // Read source selection.
    always_comb begin
        case (rd_src)
            RS_ADDR: rd_val = addr_q;
            RS_CTRL: rd_val = ctrl_q;
            RS_PAGE: rd_val = page_q;
            RS_SEGC: rd_val = segc_q;
            RS_DSEL: rd_val = dsel_q;
            RS_STLO: rd_val = status_in[HW-1:0];
            RS_STHI: rd_val = status_in[SW-1:HW];
            RS_PSRC: rd_val = {PADW'(DEV_ID), psrc_ins};
            RS_PDST: rd_val = {{PADW{1'b0}}, pdst_ins};
            RS_CMP:  rd_val = cmp_q;
            RS_MSK1: rd_val = msk1_q;
            RS_MSK2: rd_val = msk2_q;
            RS_ARR:  rd_val = array_rdata;
            default: rd_val = nfa_in;
        endcase
    end

    // Registered read port and drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else begin
            rdata_oe <= rd_en;
            if (rd_en) rdata <= rd_val;
        end
    end
endmodule

// File: rtl/hbac_top.sv
`timescale 1ns/1ps
// Host bus access controller: classifies strobed bus cycles, gates them by
// device selection and routes them to registers or array strobes.
// Assumes one strobe per bus cycle and array read data valid in that cycle.
module hbac_top
    import hbac_pkg::*;
#(
    parameter logic [3:0]  DEV_ID   = 4'h5,
    parameter logic [15:0] PAGE_RST = 16'h0000,
    parameter logic [15:0] DSEL_RST = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_stb,
    input  logic        ce_n,
    input  logic        cd_n,
    input  logic        wr_n,
    input  logic [15:0] wdata,
    input  logic [15:0] nfa_in,
    input  logic [31:0] status_in,
    input  logic [15:0] array_rdata,
    output logic [15:0] rdata,
    output logic        rdata_oe,
    output logic        instr_stb,
    output logic [15:0] instr_q,
    output logic [15:0] addr_q,
    output logic        arr_wr_stb,
    output logic        arr_rd_stb,
    output logic [1:0]  arr_sel
);
    cyc_e          cyc;
    logic          acc, dsel_try, ld_instr, rd_en;
    host_we_t      we;
    rsrc_e         rd_src;
    asel_e         asel;
    logic [IW-1:0] psrc_ins, pdst_ins;
    logic [HW-1:0] page_q, dsel_q;

    hbac_cycle_class u_class (
        .cyc_stb(cyc_stb), .ce_n(ce_n), .cd_n(cd_n), .wr_n(wr_n), .cyc(cyc)
    );

    hbac_access_gate u_gate (
        .cyc(cyc), .page_q(page_q), .dsel_q(dsel_q), .dsel_try(dsel_try), .acc(acc)
    );

    hbac_route_ctl u_route (
        .clk(clk), .rst_n(rst_n), .cyc(cyc), .acc(acc), .wdata(wdata),
        .dsel_try(dsel_try), .we(we), .ld_instr(ld_instr), .rd_en(rd_en),
        .rd_src(rd_src), .arr_wr(arr_wr_stb), .arr_rd(arr_rd_stb), .arr_sel(asel),
        .psrc_ins(psrc_ins), .pdst_ins(pdst_ins)
    );

    hbac_regfile #(.DEV_ID(DEV_ID), .PAGE_RST(PAGE_RST), .DSEL_RST(DSEL_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .ld_instr(ld_instr), .wdata(wdata),
        .rd_en(rd_en), .rd_src(rd_src), .nfa_in(nfa_in), .status_in(status_in),
        .array_rdata(array_rdata), .psrc_ins(psrc_ins), .pdst_ins(pdst_ins),
        .rdata(rdata), .rdata_oe(rdata_oe), .instr_q(instr_q), .addr_q(addr_q),
        .page_q(page_q), .dsel_q(dsel_q)
    );

    assign instr_stb = ld_instr;
    assign arr_sel   = asel;
endmodule

// File: rtl/hbac_chk.sv
`timescale 1ns/1ps
// Temporal checks on the access controller's ports and selection registers.
module hbac_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cyc_stb,
    input logic        ce_n,
    input logic        cd_n,
    input logic        wr_n,
    input logic        rdata_oe,
    input logic        instr_stb,
    input logic        arr_wr_stb,
    input logic        arr_rd_stb,
    input logic [15:0] page_q,
    input logic [15:0] dsel_q
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && ce_n) |=> !rdata_oe);

    a_r10_oe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> $past(cyc_stb && !ce_n && wr_n));

    a_r2_instr_on_cmd_write: assert property (@(posedge clk) disable iff (!rst_n)
        instr_stb |-> (cyc_stb && !ce_n && !cd_n && !wr_n));

    a_r7_wr_stb_on_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_stb |-> (cyc_stb && !ce_n && cd_n && !wr_n));

    a_r7_rd_stb_on_data_read: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd_stb |-> (cyc_stb && !ce_n && cd_n && wr_n));

    a_r8_desel_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !ce_n && wr_n && (dsel_q != page_q)) |=> !rdata_oe);
endmodule

bind hbac_top hbac_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ce_n(ce_n), .cd_n(cd_n),
    .wr_n(wr_n), .rdata_oe(rdata_oe), .instr_stb(instr_stb),
    .arr_wr_stb(arr_wr_stb), .arr_rd_stb(arr_rd_stb),
    .page_q(page_q), .dsel_q(dsel_q)
);

// File: tb/sim_hbac_top.sv
`timescale 1ns/1ps
module sim_hbac_top;
    localparam logic [3:0] DEV = 4'h5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_stb = 1'b0, ce_n = 1'b1, cd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] wdata = '0, nfa_in = '0, array_rdata;
    logic [31:0] status_in = '0;
    logic [15:0] rdata, instr_q, addr_q;
    logic rdata_oe, instr_stb, arr_wr_stb, arr_rd_stb;
    logic [1:0] arr_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    // Array stub: data depends on location select and address.
    assign array_rdata = {arr_sel, 1'b0, addr_q[12:0]};

    hbac_top #(.DEV_ID(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ce_n(ce_n), .cd_n(cd_n),
        .wr_n(wr_n), .wdata(wdata), .nfa_in(nfa_in), .status_in(status_in),
        .array_rdata(array_rdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .instr_stb(instr_stb), .instr_q(instr_q), .addr_q(addr_q),
        .arr_wr_stb(arr_wr_stb), .arr_rd_stb(arr_rd_stb), .arr_sel(arr_sel)
    );

    // Bench model of the host-visible state.
    logic [15:0] m_addr, m_ctrl, m_page, m_segc, m_dsel, m_cmp, m_m1, m_m2;
    bit m_rv, m_af, m_sh;
    bit [2:0] m_rt, m_ps, m_pd;
    bit [11:0] m_psi, m_pdi;

    task automatic model_reset();
        m_addr = 0; m_ctrl = 0; m_page = 0; m_segc = 0; m_dsel = 0;
        m_cmp = 0; m_m1 = 0; m_m2 = 0;
        m_rv = 0; m_af = 0; m_sh = 0; m_rt = 0; m_ps = 0; m_pd = 0;
        m_psi = 12'h200; m_pdi = 12'h300;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] ctl_word(input bit [2:0] sub, input bit [2:0] code);
        return {4'hF, 1'b0, sub, 5'd0, code};
    endfunction

    // One bus cycle: drive at a falling edge, check strobes, then read port.
    task automatic step(input bit ce, input bit cd, input bit wr, input logic [15:0] wd);
        bit sel, wok, ipath, ctl, dtry, acc, e_oe, e_ins, e_aw, e_ar, n_sh;
        bit [2:0] sub, code;
        logic [1:0] e_as;
        logic [15:0] e_rd;
        string tag;
        nfa_in    = 16'($urandom);
        status_in = $urandom;
        sel   = (m_dsel == m_page);
        wok   = sel || (m_dsel == 16'hFFFF);
        ctl   = (wd[15:12] == 4'hF) && (wd[7:3] == 5'd0);
        sub   = wd[10:8];
        code  = wd[2:0];
        ipath = !cd && !wr && !m_rv && !m_af;
        dtry  = !cd && !wr && ((m_rv && m_rt == 3'd4) || (ipath && ctl && sub == 3'd1 && code == 3'd4));
        acc   = !ce && (!wr ? (wok || dtry) : sel);
        e_oe = 0; e_ins = 0; e_aw = 0; e_ar = 0; e_as = 0; e_rd = 0;
        tag = ce ? "R1" : (acc ? "R2" : "R8");
        if (acc) begin
            if (!cd && !wr) begin
                if (m_rv) tag = "R4"; else if (m_af) tag = "R3"; else e_ins = 1;
            end else if (!cd && wr) begin
                e_oe = 1;
                if (m_rv) begin
                    tag = "R4";
                    case (m_rt)
                        3'd0: e_rd = m_addr;
                        3'd1: e_rd = m_ctrl;
                        3'd2: e_rd = m_page;
                        3'd3: e_rd = m_segc;
                        3'd4: e_rd = m_dsel;
                        3'd5: begin e_rd = status_in[15:0]; tag = "R5"; end
                        3'd6: begin e_rd = {DEV, m_psi}; tag = "R9"; end
                        default: begin e_rd = {4'h0, m_pdi}; tag = "R9"; end
                    endcase
                end else if (m_sh) begin
                    e_rd = status_in[31:16]; tag = "R5";
                end else begin
                    e_rd = nfa_in;
                end
            end else if (cd && !wr) begin
                tag = "R6";
                if (m_pd >= 3) begin
                    e_aw = 1; tag = "R7";
                    e_as = (m_pd == 3) ? 2'd0 : (m_pd == 4) ? 2'd1 : 2'd2;
                end
            end else begin
                e_oe = 1; tag = "R6";
                case (m_ps)
                    3'd0: e_rd = m_cmp;
                    3'd1: e_rd = m_m1;
                    3'd2: e_rd = m_m2;
                    default: begin
                        e_ar = 1; tag = "R7";
                        e_as = (m_ps == 3) ? 2'd0 : 2'd2;
                        e_rd = {e_as, 1'b0, m_addr[12:0]};
                    end
                endcase
            end
        end
        cyc_stb = 1; ce_n = ce; cd_n = cd; wr_n = wr; wdata = wd;
        #1;
        chk(tag, instr_stb, e_ins);
        chk(tag, arr_wr_stb, e_aw);
        chk(tag, arr_rd_stb, e_ar);
        if (e_aw || e_ar) chk(tag, arr_sel, e_as);
        @(negedge clk);
        cyc_stb = 0;
        chk("R10", rdata_oe, e_oe);
        if (e_oe) chk(tag, rdata, e_rd);
        if (e_ins) chk("R2", instr_q, wd);
        if (acc) begin
            if (!cd && !wr) begin
                if (m_rv) begin
                    case (m_rt)
                        3'd0: m_addr = wd;
                        3'd1: m_ctrl = wd;
                        3'd2: m_page = wd;
                        3'd3: m_segc = wd;
                        3'd4: m_dsel = wd;
                        default: ;
                    endcase
                end else if (m_af) begin
                    m_addr = wd;
                end else if (ctl && sub == 3'd2 && (code <= 3 || code == 5)) begin
                    m_ps = code; m_psi = wd[11:0];
                end else if (ctl && sub == 3'd3 && code <= 5) begin
                    m_pd = code; m_pdi = wd[11:0];
                end
            end else if (cd && !wr) begin
                case (m_pd)
                    3'd0: m_cmp = wd;
                    3'd1: m_m1 = wd;
                    3'd2: m_m2 = wd;
                    default: ;
                endcase
            end
            n_sh = !cd && wr && m_rv && m_rt == 3'd5;
            m_rv = ipath && ctl && sub == 3'd1;
            m_af = ipath && !ctl && wd[11];
            m_rt = code;
            m_sh = n_sh;
        end
    endtask

    task automatic cmd_wr(input logic [15:0] wd); step(0, 0, 0, wd); endtask
    task automatic cmd_rd();                      step(0, 0, 1, 16'h0); endtask
    task automatic dat_wr(input logic [15:0] wd); step(0, 1, 0, wd); endtask
    task automatic dat_rd();                      step(0, 1, 1, 16'h0); endtask

    // Random data word biased toward useful values for the pending target.
    function automatic logic [15:0] pick_word(input bit cd, input bit wr);
        int k;
        k = $urandom_range(0, 9);
        if (!cd && !wr && !m_rv && !m_af) begin
            case (k % 6)
                0, 1: return {4'hF, 1'($urandom), 3'd1, 5'd0, 3'($urandom)};
                2:    return {4'hF, 1'($urandom), 3'd2, 5'd0, 3'($urandom)};
                3:    return {4'hF, 1'($urandom), 3'd3, 5'd0, 3'($urandom)};
                default: return {4'($urandom_range(0, 14)), 12'($urandom)};
            endcase
        end
        if (!cd && !wr && m_rv && m_rt == 3'd2) return (k < 7) ? m_dsel : 16'($urandom);
        if (!cd && !wr && m_rv && m_rt == 3'd4)
            return (k < 6) ? m_page : (k < 8) ? 16'hFFFF : 16'($urandom);
        return 16'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        chk("R11", rdata_oe, 0);
        chk("R11", instr_stb, 0);
        rst_n = 1;
        @(negedge clk);
        // Defaults after reset
        cmd_rd();
        dat_rd();
        step(1, 0, 1, 16'h0);                          // R1 ignored read
        cmd_wr(ctl_word(3'd1, 3'd6)); cmd_rd();         // R9 source readback default
        cmd_wr(ctl_word(3'd1, 3'd7)); cmd_rd();         // R9 destination readback default
        // One-shot redirection and its expiry
        cmd_wr(ctl_word(3'd1, 3'd0)); cmd_wr(16'h1234);
        cmd_rd();                                       // R4 back to default
        cmd_wr(ctl_word(3'd1, 3'd0)); cmd_rd();         // R4 address readback
        cmd_wr(ctl_word(3'd1, 3'd0)); dat_wr(16'h0F0F); cmd_wr(16'h2222); // R4 consumed by data
        // Address flag
        cmd_wr(16'h0800); cmd_wr(16'h0ABC);
        cmd_wr(ctl_word(3'd1, 3'd0)); cmd_rd();         // R3
        cmd_wr(16'h0800); cmd_rd(); cmd_wr(16'h0101);   // R3 cleared by intervening read
        // Status sequencing
        cmd_wr(ctl_word(3'd1, 3'd5)); cmd_rd(); cmd_rd(); cmd_rd();          // R5
        cmd_wr(ctl_word(3'd1, 3'd5)); cmd_rd(); dat_wr(16'h7777); cmd_rd();  // R5 broken
        // Persistent routing, invalid code ignored
        cmd_wr(ctl_word(3'd2, 3'd4)); dat_rd();                              // R6
        cmd_wr(ctl_word(3'd3, 3'd1)); dat_wr(16'hBEEF);
        cmd_wr(ctl_word(3'd2, 3'd1)); dat_rd();                              // R6
        cmd_wr(ctl_word(3'd3, 3'd4)); dat_wr(16'h1111);                      // R7 next free
        cmd_wr(ctl_word(3'd2, 3'd5)); dat_rd();                              // R7 match
        cmd_wr(ctl_word(3'd1, 3'd6)); cmd_rd();                              // R9
        cmd_wr(ctl_word(3'd2, 3'd0)); cmd_wr(ctl_word(3'd3, 3'd0));
        // Deselection and device-select write
        cmd_wr(ctl_word(3'd1, 3'd2)); cmd_wr(16'h0001);
        cmd_rd(); dat_wr(16'hDEAD); cmd_wr(16'h0042);                        // R8 ignored
        cmd_wr(ctl_word(3'd1, 3'd4)); cmd_wr(16'h0001);                      // R8 reselect
        dat_rd();
        cmd_wr(ctl_word(3'd1, 3'd4)); cmd_wr(16'hFFFF);                      // R8 write-only
        cmd_rd(); dat_wr(16'h5A5A);
        cmd_wr(ctl_word(3'd1, 3'd4)); cmd_wr(16'h0001);
        dat_rd();
        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit ce, cd, wr;
            ce = ($urandom_range(0, 9) == 0);
            cd = ($urandom_range(0, 9) < 4);
            wr = 1'($urandom);
            step(ce, cd, wr, pick_word(cd, wr));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule